// File: doc/BRIEF.md
# USB Endpoint Handshake Status Controller

This block keeps the control state of one USB device endpoint. Each direction has a receive or transmit status field, a DATA0/DATA1 toggle bit and a sticky correct-transfer flag. A protocol engine hands it one decoded transaction event per cycle. The event carries the token kind, an address/endpoint match bit, a CRC-good bit for data packets and the PID of a received data packet. The block then chooses the reply to send (ACK, NAK, STALL, a DATA packet with a chosen PID, or silence) and updates its own state.

Software reaches the state through a byte-wide register port. Select 0 is the receive register and select 1 is the transmit register. Both use the same layout: bit 3 is the correct-transfer flag, bit 2 is the toggle, bits 1:0 are the status, and all higher bits read as zero. The status code is 00 disabled, 01 stall, 10 NAK and 11 valid. Event kinds are 00 OUT (token plus data), 01 IN token, 10 SETUP (token plus data) and 11 host ACK. Reply codes are 00 ACK, 01 NAK, 10 STALL and 11 DATA. The two correct-transfer flags are brought out as interrupt requests.

Hardware takes over from software. A good transfer returns that direction to NAK so software must re-arm it. An accepted SETUP returns both directions to NAK. Any STALL reply forces both directions to stall.

Top module: `ep_hs_ctrl`

## Requirements
- R1: An event for a direction whose status is 00 (disabled) produces no reply and changes no state.
- R2: A request in a direction whose status is 10 gets reply NAK, and the status is left unchanged.
- R3: Whenever the reply is STALL (the direction's status is 01), both status fields become 01.
- R4: A CRC-good OUT in receive status 11 whose PID bit equals the receive toggle gets ACK. It sets the receive flag, inverts the receive toggle and sets the receive status to 10. An OUT with a CRC error gets no reply and changes nothing.
- R5: A CRC-good OUT in receive status 11 whose PID bit differs from the receive toggle gets ACK and changes no state.
- R6: A CRC-good SETUP while the receive status is not 00 gets ACK whatever the status is. It sets both status fields to 10, both toggles to 1 and the receive flag. With receive status 00 the SETUP is ignored.
- R7: An IN in transmit status 11 gets reply DATA with PID equal to the transmit toggle. Only a host ACK as the very next matched event inverts the transmit toggle, sets the transmit flag and sets the transmit status to 10.
- R8: The correct-transfer flags are cleared only by a software write with bit 3 at 0. A write with bit 3 at 1 leaves them unchanged.
- R9: Software writes set the toggle (bit 2) and status (bits 1:0) directly. Bits above bit 3 always read as 0.
- R10: A USB reset cycle clears both toggles and both status fields and keeps both flags. An event in that cycle is ignored.
- R11: When a hardware update and a software write hit the same register in one cycle, the hardware update is kept and the write is dropped.
- R12: The reply is registered. It is valid for exactly the one cycle after a matched event, and an event without address match is ignored.
- R13: After the asynchronous reset all register bits and the reply-valid output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usb_rst | input | 1 | USB bus reset or software-forced reset, one cycle per pulse |
| ev_valid | input | 1 | Transaction event present this cycle |
| ev_kind | input | 2 | Event kind: 00 OUT, 01 IN, 10 SETUP, 11 host ACK |
| ev_match | input | 1 | Address and endpoint number match |
| ev_crc_ok | input | 1 | Data packet CRC good (OUT, SETUP) |
| ev_pid1 | input | 1 | Received data packet was DATA1 |
| hs_valid | output | 1 | Reply present this cycle |
| hs_code | output | 2 | Reply: 00 ACK, 01 NAK, 10 STALL, 11 DATA |
| hs_pid | output | 1 | PID of the DATA reply (1 = DATA1) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 receive, 1 transmit |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register |
| irq_rx | output | 1 | Receive correct-transfer flag |
| irq_tx | output | 1 | Transmit correct-transfer flag |

## Verification
The bench builds the block with the default register width of 8 bits. Writes of ones into bits 7:4 can therefore show that the upper nibble always reads zero. Every status code is visited in both directions. The bench drives an IN followed by a host ACK, and also an IN whose ACK is preceded by another event, so both sides of the ACK pairing are exercised. A software write is placed in the same cycle as a hardware update, and a USB reset is placed in the same cycle as an event, to cover both priority rules.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;

  localparam int FLAG_BIT = 3;
  localparam int TOG_BIT  = 2;
  localparam int NIB_W    = 4;

  typedef enum logic [1:0] {
    ST_DIS   = 2'b00,
    ST_STALL = 2'b01,
    ST_NAK   = 2'b10,
    ST_VALID = 2'b11
  } ep_stat_e;

  typedef enum logic [1:0] {
    EV_OUT   = 2'b00,
    EV_IN    = 2'b01,
    EV_SETUP = 2'b10,
    EV_HACK  = 2'b11
  } ev_kind_e;

  typedef enum logic [1:0] {
    HS_ACK   = 2'b00,
    HS_NAK   = 2'b01,
    HS_STALL = 2'b10,
    HS_DATA  = 2'b11
  } hs_code_e;

  typedef struct packed {
    logic     flag;
    logic     tog;
    ep_stat_e stat;
  } dir_state_t;

  typedef struct packed {
    logic     stat_we;
    ep_stat_e stat;
    logic     tog_we;
    logic     tog;
    logic     flag_set;
  } dir_upd_t;

  // Reply for a non-valid, non-disabled status.
  function automatic hs_code_e status_reply(ep_stat_e s);
    return (s == ST_STALL) ? HS_STALL : HS_NAK;
  endfunction

  // Software write: flag can only be cleared, toggle and status are loaded.
  function automatic dir_state_t sw_merge(dir_state_t cur, logic [NIB_W-1:0] w);
    dir_state_t n;
    n.flag = cur.flag & w[FLAG_BIT];
    n.tog  = w[TOG_BIT];
    n.stat = ep_stat_e'(w[1:0]);
    return n;
  endfunction

  // Hardware update applied on top of the current state.
  function automatic dir_state_t hw_apply(dir_state_t cur, dir_upd_t u);
    dir_state_t n;
    n      = cur;
    if (u.stat_we)  n.stat = u.stat;
    if (u.tog_we)   n.tog  = u.tog;
    if (u.flag_set) n.flag = 1'b1;
    return n;
  endfunction

endpackage

// File: rtl/ep_hs_decide.sv
module ep_hs_decide
  import ep_hs_pkg::*;
(
  input  logic       ev_valid,
  input  logic [1:0] ev_kind,
  input  logic       ev_match,
  input  logic       ev_crc_ok,
  input  logic       ev_pid1,
  input  logic       blk,
  input  dir_state_t rx,
  input  dir_state_t tx,
  input  logic       in_wait,
  output dir_upd_t   upd_rx,
  output dir_upd_t   upd_tx,
  output logic       fire,
  output logic [1:0] code,
  output logic       pid,
  output logic       wait_nxt,
  output logic       ok_out,
  output logic       setup_acc,
  output logic       stall_ret,
  output logic       in_ack
);

  logic     go;
  hs_code_e code_e;

  assign go   = ev_valid & ev_match & ~blk;
  assign code = code_e;

  always_comb begin
    fire      = 1'b0;
    code_e    = HS_ACK;
    pid       = 1'b0;
    ok_out    = 1'b0;
    setup_acc = 1'b0;
    stall_ret = 1'b0;
    in_ack    = 1'b0;
    wait_nxt  = in_wait & ~go & ~blk;
    if (go) begin
      case (ev_kind_e'(ev_kind))
        EV_OUT: begin
          if (ev_crc_ok && rx.stat != ST_DIS) begin
            fire      = 1'b1;
            stall_ret = (rx.stat == ST_STALL);
            if (rx.stat == ST_VALID) begin
              code_e = HS_ACK;
              ok_out = (ev_pid1 == rx.tog);
            end else begin
              code_e = status_reply(rx.stat);
            end
          end
        end
        EV_SETUP: begin
          if (ev_crc_ok && rx.stat != ST_DIS) begin
            fire      = 1'b1;
            code_e    = HS_ACK;
            setup_acc = 1'b1;
          end
        end
        EV_IN: begin
          if (tx.stat != ST_DIS) begin
            fire      = 1'b1;
            stall_ret = (tx.stat == ST_STALL);
            if (tx.stat == ST_VALID) begin
              code_e   = HS_DATA;
              pid      = tx.tog;
              wait_nxt = 1'b1;
            end else begin
              code_e = status_reply(tx.stat);
            end
          end
        end
        EV_HACK: in_ack = in_wait;
        default: ;
      endcase
    end
  end

  always_comb begin
    upd_rx = '0;
    upd_tx = '0;
    if (stall_ret) begin
      upd_rx.stat_we = 1'b1;  upd_rx.stat = ST_STALL;
      upd_tx.stat_we = 1'b1;  upd_tx.stat = ST_STALL;
    end
    if (ok_out) begin
      upd_rx.stat_we  = 1'b1;  upd_rx.stat = ST_NAK;
      upd_rx.tog_we   = 1'b1;  upd_rx.tog  = ~rx.tog;
      upd_rx.flag_set = 1'b1;
    end
    if (setup_acc) begin
      upd_rx.stat_we  = 1'b1;  upd_rx.stat = ST_NAK;
      upd_tx.stat_we  = 1'b1;  upd_tx.stat = ST_NAK;
      upd_rx.tog_we   = 1'b1;  upd_rx.tog  = 1'b1;
      upd_tx.tog_we   = 1'b1;  upd_tx.tog  = 1'b1;
      upd_rx.flag_set = 1'b1;
    end
    if (in_ack) begin
      upd_tx.stat_we  = 1'b1;  upd_tx.stat = ST_NAK;
      upd_tx.tog_we   = 1'b1;  upd_tx.tog  = ~tx.tog;
      upd_tx.flag_set = 1'b1;
    end
  end

endmodule

// File: rtl/ep_dir_reg.sv
module ep_dir_reg
  import ep_hs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  dir_upd_t            upd,
  input  logic                sw_we,
  input  logic [NIB_W-1:0]    sw_data,
  output dir_state_t          st,
  output logic [DATA_W-1:0]   rd
);

  localparam int PAD_W = DATA_W - NIB_W;

  logic hw_busy;
  assign hw_busy = upd.stat_we | upd.tog_we | upd.flag_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0;
    end else if (clr) begin
      st.stat <= ST_DIS;
      st.tog  <= 1'b0;
    end else if (hw_busy) begin
      st <= hw_apply(st, upd);
    end else if (sw_we) begin
      st <= sw_merge(st, sw_data);
    end
  end

  assign rd = {{PAD_W{1'b0}}, st};

endmodule

// File: rtl/ep_hs_resp.sv
module ep_hs_resp (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic [1:0] code,
  input  logic       pid,
  input  logic       wait_nxt,
  output logic       hs_valid,
  output logic [1:0] hs_code,
  output logic       hs_pid,
  output logic       in_wait
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_valid <= 1'b0;
      hs_code  <= 2'b00;
      hs_pid   <= 1'b0;
      in_wait  <= 1'b0;
    end else begin
      hs_valid <= fire;
      hs_code  <= fire ? code : 2'b00;
      hs_pid   <= fire & pid;
      in_wait  <= wait_nxt;
    end
  end

endmodule

// File: rtl/ep_hs_ctrl.sv
module ep_hs_ctrl
  import ep_hs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              usb_rst,
  input  logic              ev_valid,
  input  logic [1:0]        ev_kind,
  input  logic              ev_match,
  input  logic              ev_crc_ok,
  input  logic              ev_pid1,
  output logic              hs_valid,
  output logic [1:0]        hs_code,
  output logic              hs_pid,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_rx,
  output logic              irq_tx
);

  localparam int N_DIR = 2;

  dir_state_t        st_q [N_DIR];
  logic [DATA_W-1:0] rd   [N_DIR];
  dir_upd_t          upd_rx, upd_tx;

  logic       fire, pid, wait_nxt, in_wait;
  logic [1:0] code;
  // Named internal events, visible to the checker.
  logic       ev_ok_out, ev_setup_acc, ev_stall_ret, ev_in_ack;
  logic [1:0] rx_stat_w, tx_stat_w;
  logic       rx_flag_w, tx_flag_w, tx_tog_w;
  logic       unused_wdata_hi;

  ep_hs_decide u_decide (
    .ev_valid  (ev_valid),
    .ev_kind   (ev_kind),
    .ev_match  (ev_match),
    .ev_crc_ok (ev_crc_ok),
    .ev_pid1   (ev_pid1),
    .blk       (usb_rst),
    .rx        (st_q[0]),
    .tx        (st_q[1]),
    .in_wait   (in_wait),
    .upd_rx    (upd_rx),
    .upd_tx    (upd_tx),
    .fire      (fire),
    .code      (code),
    .pid       (pid),
    .wait_nxt  (wait_nxt),
    .ok_out    (ev_ok_out),
    .setup_acc (ev_setup_acc),
    .stall_ret (ev_stall_ret),
    .in_ack    (ev_in_ack)
  );

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    ep_dir_reg #(.DATA_W(DATA_W)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (usb_rst),
      .upd     ((d == 0) ? upd_rx : upd_tx),
      .sw_we   (reg_wr && (reg_sel == 1'(d))),
      .sw_data (reg_wdata[NIB_W-1:0]),
      .st      (st_q[d]),
      .rd      (rd[d])
    );
  end

  ep_hs_resp u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .code     (code),
    .pid      (pid),
    .wait_nxt (wait_nxt),
    .hs_valid (hs_valid),
    .hs_code  (hs_code),
    .hs_pid   (hs_pid),
    .in_wait  (in_wait)
  );

  assign reg_rdata       = reg_sel ? rd[1] : rd[0];
  assign irq_rx          = st_q[0].flag;
  assign irq_tx          = st_q[1].flag;
  assign rx_stat_w       = st_q[0].stat;
  assign tx_stat_w       = st_q[1].stat;
  assign rx_flag_w       = st_q[0].flag;
  assign tx_flag_w       = st_q[1].flag;
  assign tx_tog_w        = st_q[1].tog;
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NIB_W];

endmodule

// File: rtl/ep_hs_ctrl_chk.sv
module ep_hs_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              usb_rst,
  input logic              ev_valid,
  input logic [1:0]        ev_kind,
  input logic              ev_match,
  input logic              ev_crc_ok,
  input logic              hs_valid,
  input logic [1:0]        hs_code,
  input logic              reg_wr,
  input logic              reg_sel,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [1:0]        rx_stat,
  input logic [1:0]        tx_stat,
  input logic              rx_flag,
  input logic              tx_flag,
  input logic              tx_tog,
  input logic              ev_setup_acc,
  input logic              ev_in_ack
);

  AST_NO_REPLY_WITHOUT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid |-> $past(ev_valid && ev_match && !usb_rst)); // R12

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind == 2'b00 && rx_stat == 2'b00) |=> !hs_valid); // R1

  AST_STALL_FORCES_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && hs_code == 2'b10) |-> (rx_stat == 2'b01 && tx_stat == 2'b01)); // R3

  AST_SETUP_NAKS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev_valid && ev_match && !usb_rst && ev_kind == 2'b10 && ev_crc_ok && rx_stat != 2'b00)
    |-> (rx_stat == 2'b10 && tx_stat == 2'b10 && hs_valid && hs_code == 2'b00 && rx_flag)); // R6

  AST_TX_TOG_MOVES_ON_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tog != $past(tx_tog)) |-> $past(reg_wr || usb_rst || ev_setup_acc || ev_in_ack)); // R7

  AST_TX_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_flag) && !tx_flag) |-> $past(reg_wr && reg_sel && !reg_wdata[3] && !ev_in_ack && !usb_rst)); // R8

  AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:4] == '0); // R9

  AST_USB_RST_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(usb_rst) |-> (rx_stat == 2'b00 && tx_stat == 2'b00 && !hs_valid
                        && tx_flag == $past(tx_flag) && rx_flag == $past(rx_flag))); // R10

endmodule

bind ep_hs_ctrl ep_hs_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .usb_rst      (usb_rst),
  .ev_valid     (ev_valid),
  .ev_kind      (ev_kind),
  .ev_match     (ev_match),
  .ev_crc_ok    (ev_crc_ok),
  .hs_valid     (hs_valid),
  .hs_code      (hs_code),
  .reg_wr       (reg_wr),
  .reg_sel      (reg_sel),
  .reg_wdata    (reg_wdata),
  .reg_rdata    (reg_rdata),
  .rx_stat      (rx_stat_w),
  .tx_stat      (tx_stat_w),
  .rx_flag      (rx_flag_w),
  .tx_flag      (tx_flag_w),
  .tx_tog       (tx_tog_w),
  .ev_setup_acc (ev_setup_acc),
  .ev_in_ack    (ev_in_ack)
);

// File: tb/ep_hs_ctrl_tb.sv
`timescale 1ns/1ps
module ep_hs_ctrl_tb;

  localparam int DATA_W = 8;
  localparam logic [1:0] K_OUT = 2'b00, K_IN = 2'b01, K_SET = 2'b10, K_ACK = 2'b11;
  localparam logic [1:0] H_ACK = 2'b00, H_NAK = 2'b01, H_STL = 2'b10, H_DAT = 2'b11;

  typedef struct packed {
    logic       ev;
    logic       wr;
    logic       urst;
    logic       sel;
    logic [7:0] wdata;
    logic [1:0] kind;
    logic       match;
    logic       crc;
    logic       pid1;
    logic       hsv;
    logic [1:0] code;
    logic       hpid;
    logic [7:0] rx;
    logic [7:0] tx;
    logic [3:0] req;
  } vec_t;

  function automatic vec_t mk_ev(logic [1:0] k, logic m, logic c, logic p, logic hv,
                                 logic [1:0] hc, logic hp, logic [7:0] erx, logic [7:0] etx,
                                 logic [3:0] rq);
    vec_t v = '0;
    v.ev = 1'b1; v.kind = k; v.match = m; v.crc = c; v.pid1 = p;
    v.hsv = hv; v.code = hc; v.hpid = hp; v.rx = erx; v.tx = etx; v.req = rq;
    return v;
  endfunction

  function automatic vec_t mk_wr(logic s, logic [7:0] d, logic [7:0] erx, logic [7:0] etx,
                                 logic [3:0] rq);
    vec_t v = '0;
    v.wr = 1'b1; v.sel = s; v.wdata = d; v.rx = erx; v.tx = etx; v.req = rq;
    return v;
  endfunction

  localparam int NV = 32;
  localparam vec_t TBL [NV] = '{
    mk_ev(K_OUT,1,1,0, 0,H_ACK,0, 8'h00,8'h00, 1),  // R1 rx disabled
    mk_wr(0,8'h03, 8'h03,8'h00, 9),                  // R9
    mk_wr(1,8'hF3, 8'h03,8'h03, 9),                  // R9 upper bits dropped
    mk_ev(K_OUT,0,1,0, 0,H_ACK,0, 8'h03,8'h03, 12), // R12 no match
    mk_ev(K_OUT,1,1,0, 1,H_ACK,0, 8'h0E,8'h03, 4),  // R4
    mk_ev(K_OUT,1,1,1, 1,H_NAK,0, 8'h0E,8'h03, 2),  // R2
    mk_wr(0,8'h0F, 8'h0F,8'h03, 8),                  // R8 write 1 keeps flag
    mk_ev(K_OUT,1,0,1, 0,H_ACK,0, 8'h0F,8'h03, 4),  // R4 crc error
    mk_ev(K_OUT,1,1,0, 1,H_ACK,0, 8'h0F,8'h03, 5),  // R5 toggle mismatch
    mk_wr(0,8'h07, 8'h07,8'h03, 8),                  // R8 clear
    mk_ev(K_OUT,1,1,1, 1,H_ACK,0, 8'h0A,8'h03, 4),  // R4
    mk_ev(K_IN ,1,1,0, 1,H_DAT,0, 8'h0A,8'h03, 7),  // R7
    mk_ev(K_ACK,1,1,0, 0,H_ACK,0, 8'h0A,8'h0E, 7),  // R7
    mk_ev(K_IN ,1,1,0, 1,H_NAK,0, 8'h0A,8'h0E, 2),  // R2
    mk_ev(K_ACK,1,1,0, 0,H_ACK,0, 8'h0A,8'h0E, 7),  // R7 stray ack
    mk_wr(1,8'h0B, 8'h0A,8'h0B, 8),                  // R8
    mk_ev(K_IN ,1,1,0, 1,H_DAT,0, 8'h0A,8'h0B, 7),  // R7
    mk_ev(K_OUT,1,1,1, 1,H_NAK,0, 8'h0A,8'h0B, 7),  // R7 breaks pairing
    mk_ev(K_ACK,1,1,0, 0,H_ACK,0, 8'h0A,8'h0B, 7),  // R7 late ack ignored
    mk_wr(0,8'h09, 8'h09,8'h0B, 9),                  // R9
    mk_ev(K_OUT,1,1,0, 1,H_STL,0, 8'h09,8'h09, 3),  // R3
    mk_ev(K_SET,1,1,0, 1,H_ACK,0, 8'h0E,8'h0E, 6),  // R6 over stall
    mk_ev(K_IN ,1,1,0, 1,H_NAK,0, 8'h0E,8'h0E, 2),  // R2
    mk_wr(1,8'h01, 8'h0E,8'h01, 8),                  // R8
    mk_ev(K_IN ,1,1,0, 1,H_STL,0, 8'h0D,8'h01, 3),  // R3
    mk_wr(0,8'h00, 8'h00,8'h01, 1),                  // R1
    mk_ev(K_SET,1,1,0, 0,H_ACK,0, 8'h00,8'h01, 6),  // R6 disabled
    mk_wr(1,8'h00, 8'h00,8'h00, 1),                  // R1
    mk_ev(K_IN ,1,1,0, 0,H_ACK,0, 8'h00,8'h00, 1),  // R1 tx disabled
    mk_wr(1,8'h07, 8'h00,8'h07, 9),                  // R9 force DATA1
    mk_ev(K_IN ,1,1,0, 1,H_DAT,1, 8'h00,8'h07, 7),  // R7 pid 1
    mk_ev(K_ACK,1,1,0, 0,H_ACK,0, 8'h00,8'h0A, 7)   // R7
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              usb_rst = 1'b0;
  logic              ev_valid = 1'b0;
  logic [1:0]        ev_kind = 2'b00;
  logic              ev_match = 1'b0;
  logic              ev_crc_ok = 1'b0;
  logic              ev_pid1 = 1'b0;
  logic              hs_valid;
  logic [1:0]        hs_code;
  logic              hs_pid;
  logic              reg_wr = 1'b0;
  logic              reg_sel = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              irq_rx, irq_tx;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ep_hs_ctrl #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .usb_rst(usb_rst),
    .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_match(ev_match),
    .ev_crc_ok(ev_crc_ok), .ev_pid1(ev_pid1),
    .hs_valid(hs_valid), .hs_code(hs_code), .hs_pid(hs_pid),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic read_both(string req, logic [7:0] erx, logic [7:0] etx);
    reg_sel = 1'b0; #1;
    chk(reg_rdata == erx, req, "rx register", reg_rdata, erx);
    reg_sel = 1'b1; #1;
    chk(reg_rdata == etx, req, "tx register", reg_rdata, etx);
  endtask

  task automatic run_vec(vec_t v);
    string rq;
    rq = $sformatf("R%0d", v.req);
    ev_valid = v.ev;   ev_kind = v.kind; ev_match = v.match;
    ev_crc_ok = v.crc; ev_pid1 = v.pid1;
    reg_wr = v.wr;     reg_sel = v.sel;  reg_wdata = v.wdata;
    usb_rst = v.urst;
    @(negedge clk);
    ev_valid = 1'b0; reg_wr = 1'b0; usb_rst = 1'b0;
    chk(hs_valid == v.hsv, rq, "reply valid", hs_valid, v.hsv);
    if (v.hsv) begin
      chk(hs_code == v.code, rq, "reply code", hs_code, v.code);
      if (v.code == H_DAT) chk(hs_pid == v.hpid, rq, "data pid", hs_pid, v.hpid);
    end
    read_both(rq, v.rx, v.tx);
  endtask

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13: reset state
    chk(hs_valid == 1'b0, "R13", "reply valid", hs_valid, 0);
    chk(irq_rx == 1'b0 && irq_tx == 1'b0, "R13", "irq", {irq_rx, irq_tx}, 0);
    read_both("R13", 8'h00, 8'h00);

    for (int i = 0; i < NV; i++) run_vec(TBL[i]);

    // R4 path to get a set receive flag before the bus reset
    run_vec(mk_wr(0, 8'h07, 8'h07, 8'h0A, 9));
    run_vec(mk_ev(K_OUT,1,1,1, 1,H_ACK,0, 8'h0A,8'h0A, 4));
    // R10: usb reset with a concurrent IN, flags kept, event ignored
    v = mk_ev(K_IN,1,1,0, 0,H_ACK,0, 8'h08,8'h08, 10);
    v.urst = 1'b1;
    run_vec(v);
    chk(irq_rx == 1'b1 && irq_tx == 1'b1, "R10", "irq after usb reset", {irq_rx, irq_tx}, 2'b11);
    run_vec(mk_wr(0, 8'h07, 8'h07, 8'h08, 8));
    // R11: hardware update and software write in the same cycle
    v = mk_ev(K_OUT,1,1,1, 1,H_ACK,0, 8'h0A,8'h08, 11);
    v.wr = 1'b1; v.sel = 1'b0; v.wdata = 8'h03;
    run_vec(v);
    // R12: reply lasts one cycle
    v = '0; v.rx = 8'h0A; v.tx = 8'h08; v.req = 12;
    run_vec(v);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule